// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block holds the control and status words of a system control unit behind a simple word-wide register bus. A master issues one access per cycle with `bus_wr` or `bus_rd`, a byte address, a size code and write data. Read data and an error pulse with a 2-bit reason code come back one clock later. Status values such as a frequency measurement, eight display scratch words, a random-number word and a 64-bit free-running count are produced elsewhere in the chip. They arrive on input ports and are only passed through on reads.

A small key state machine guards a window of registers. It has two states. `KS_LOCKED` is the reset state. `KS_OPEN` is entered by the transition "key match", which is a write to the key register carrying the magic value. A key write with any other value takes the transition "key miss" back to `KS_LOCKED`. When neither kind of key write happens, the transition "hold" keeps the current state. The key register stores only this state, never the key word, and reads back as 0 or 1.

The parameter `NEWGEN` selects between two chip generations at compile time. In the newer generation (`NEWGEN`=1), a write to the strap register sets bits, and a write to the revision address clears strap bits. In the older generation (`NEWGEN`=0), the revision register is read-only and a strap write replaces the whole word.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, the key register (word index 0) reads 0. The strap register (index 1) reads `STRAP_RST`. The revision register (index 2) reads `REV_NEW` when `NEWGEN`=1 and `REV_OLD` when `NEWGEN`=0. Every general register (index 15 to `NUM_REGS`-1) reads 0, and `err_pulse` is low.
- R2: A write to index 0 puts the key state in `KS_OPEN` when the write data equals `KEY_VALUE`, and in `KS_LOCKED` for any other data. Index 0 reads as 1 when open and 0 when locked, and a key write never raises an error.
- R3: Indices from 1 to `LOCK_END`-1 form the protected window. A write to a writable register in this window while locked changes nothing and reports code 2 (locked). The same write while open takes effect.
- R4: With `NEWGEN`=1, a write to index 1 ORs the write data into the strap word.
- R5: With `NEWGEN`=1, a write to index 2 clears every strap bit that is 1 in the write data. The revision value stays unchanged and no error is reported.
- R6: With `NEWGEN`=0, a write to index 2 changes nothing and reports code 1 (read-only). A write to index 1 replaces the strap word.
- R7: The following indices are read-only in both generations: 3 (frequency evaluation), 4 to 11 (scratch words 0 to 7, packed 32 bits each from the low end of `ro_scratch`), 12 (random data), 13 (count low word) and 14 (count high word). Reads return the input port, and writes report code 1 with no effect. Code 1 takes priority over code 2.
- R8: An access to a word index at or above `NUM_REGS` reports code 0 (out of bounds). Such a write changes nothing, and such a read returns 0.
- R9: Only word accesses are valid: `bus_size`=2'b10 with `bus_addr[1:0]`=0. Any other access reports code 3, changes nothing, and a read of that kind returns 0. Code 3 takes priority over all other codes.
- R10: The general registers take the full write data and read it back unchanged. Those at or above `LOCK_END` are writable even while locked.
- R11: `bus_rdata`, `err_pulse` and `err_code` change at the clock edge that follows the access. The error pulse lasts one cycle per failing access. When both `bus_wr` and `bus_rd` are high, the access is treated as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; word index is `bus_addr[ADDR_W-1:2]` |
| bus_size | input | 2 | Access size code, 2'b10 = 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| err_pulse | output | 1 | One-cycle error indication |
| err_code | output | 2 | 0 out of bounds, 1 read-only, 2 locked, 3 bad size |
| ro_freq_eval | input | 32 | Frequency evaluation status |
| ro_scratch | input | 256 | Eight scratch words, word k at bits 32k+31:32k |
| ro_rng | input | 32 | Random-number data |
| ro_cnt_lo | input | 32 | Free-running count, low word |
| ro_cnt_hi | input | 32 | Free-running count, high word |

## Verification
The hardest behaviour to observe at the ports is the difference between the generations: the same write to the revision address must clear strap bits in one generation and be refused in the other, while the revision value itself never changes. The bench places one instance of each generation on the same bus in lockstep. It first sets strap bits by OR, then clears a subset through the revision address, then reads both strap words back. The two instances must give different results from identical stimulus. Locked-window blocking is reached the same way: a write is tried inside the window and just past its upper edge before the key is written, and then tried again after the key write.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DW         = 32;
    // Word indices whose position matters to the protection window
    localparam int KEY_IDX    = 0;
    localparam int STRAP_IDX  = 1;
    localparam int REV_IDX    = 2;
    localparam int FREQ_IDX   = 3;
    localparam int SCR_BASE   = 4;
    localparam int SCR_NUM    = 8;
    localparam int SCR_SEL_W  = $clog2(SCR_NUM);
    localparam int RNG_IDX    = SCR_BASE + SCR_NUM;
    localparam int CNT_LO_IDX = RNG_IDX + 1;
    localparam int CNT_HI_IDX = RNG_IDX + 2;
    localparam int GEN_BASE   = CNT_HI_IDX + 1;

    localparam logic [1:0] SIZE_WORD = 2'b10;

    typedef enum logic [1:0] {
        ERR_OOB  = 2'd0,
        ERR_RO   = 2'd1,
        ERR_LOCK = 2'd2,
        ERR_SIZE = 2'd3
    } err_code_e;

    typedef enum logic [2:0] {
        W_NONE,
        W_KEY,
        W_STRAP_SET,
        W_STRAP_CLR,
        W_STRAP_LOAD,
        W_GEN
    } wr_act_e;

    typedef enum logic {
        KS_LOCKED = 1'b0,
        KS_OPEN   = 1'b1
    } key_state_e;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 48,
    parameter int LOCK_END = 40,
    parameter bit NEWGEN   = 1'b1
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              unlocked,
    output logic [ADDR_W-3:0] idx,
    output wr_act_e           act,
    output logic              rd_hit,
    output logic              err,
    output err_code_e         code
);

    localparam int IDX_W = ADDR_W - 2;
    localparam wr_act_e STRAP_ACT = NEWGEN ? W_STRAP_SET : W_STRAP_LOAD;

    logic bad_size;
    logic in_range;
    logic is_ro;
    logic in_window;

    always_comb begin
        idx       = addr[ADDR_W-1:2];
        bad_size  = (size != SIZE_WORD) || (addr[1:0] != 2'b00);
        in_range  = {1'b0, idx} < (IDX_W+1)'(NUM_REGS);
        is_ro     = (idx == IDX_W'(FREQ_IDX))
                 || ((idx >= IDX_W'(SCR_BASE)) && (idx < IDX_W'(SCR_BASE + SCR_NUM)))
                 || (idx == IDX_W'(RNG_IDX))
                 || (idx == IDX_W'(CNT_LO_IDX))
                 || (idx == IDX_W'(CNT_HI_IDX))
                 || ((idx == IDX_W'(REV_IDX)) && !NEWGEN);
        in_window = (idx > IDX_W'(KEY_IDX)) && (idx < IDX_W'(LOCK_END));
    end

    always_comb begin
        act    = W_NONE;
        rd_hit = 1'b0;
        err    = 1'b0;
        code   = ERR_OOB;
        if (wr || rd) begin
            if (bad_size) begin
                err  = 1'b1;
                code = ERR_SIZE;
            end else if (!in_range) begin
                err  = 1'b1;
                code = ERR_OOB;
            end else if (wr) begin
                if (idx == IDX_W'(KEY_IDX)) begin
                    act = W_KEY;
                end else if (is_ro) begin
                    err  = 1'b1;
                    code = ERR_RO;
                end else if (in_window && !unlocked) begin
                    err  = 1'b1;
                    code = ERR_LOCK;
                end else if (idx == IDX_W'(REV_IDX)) begin
                    act = W_STRAP_CLR;
                end else if (idx == IDX_W'(STRAP_IDX)) begin
                    act = STRAP_ACT;
                end else begin
                    act = W_GEN;
                end
            end else begin
                rd_hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sysctl_keyfsm.sv
module sysctl_keyfsm
    import sysctl_pkg::*;
#(
    parameter logic [31:0] KEY_VALUE = 32'hA5C3_1E70
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_wr,
    input  logic [DW-1:0] wdata,
    output logic          unlocked
);

    key_state_e state_q;
    key_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_LOCKED: if (key_wr && (wdata == KEY_VALUE)) state_d = KS_OPEN;
            KS_OPEN:   if (key_wr && (wdata != KEY_VALUE)) state_d = KS_LOCKED;
        endcase
    end

    always_comb begin
        unlocked = (state_q == KS_OPEN);
    end

    // R2
    key_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && (wdata == KEY_VALUE)) |=> unlocked);

    // R2
    key_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && (wdata != KEY_VALUE)) |=> !unlocked);

    // R3
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> $stable(unlocked));

endmodule

// File: rtl/sysctl_strap.sv
module sysctl_strap
    import sysctl_pkg::*;
#(
    parameter logic [31:0] STRAP_RST = 32'h0000_0F00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wr_act_e       op,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] strap_q
);

    logic [DW-1:0] strap_d;

    always_comb begin
        strap_d = strap_q;
        unique case (op)
            W_STRAP_SET:  strap_d = strap_q | wdata;
            W_STRAP_CLR:  strap_d = strap_q & ~wdata;
            W_STRAP_LOAD: strap_d = wdata;
            default:      strap_d = strap_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= STRAP_RST;
        else        strap_q <= strap_d;
    end

    // R4
    strap_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == W_STRAP_SET) |=>
            (((strap_q & $past(wdata)) == $past(wdata))
          && ((strap_q & $past(strap_q)) == $past(strap_q))));

    // R5
    strap_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == W_STRAP_CLR) |=> ((strap_q & $past(wdata)) == '0));

    // R3
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((op == W_STRAP_SET) || (op == W_STRAP_CLR) || (op == W_STRAP_LOAD))
            |=> $stable(strap_q));

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          NUM_REGS  = 48,
    parameter int          LOCK_END  = 40,
    parameter bit          NEWGEN    = 1'b1,
    parameter logic [31:0] KEY_VALUE = 32'hA5C3_1E70,
    parameter logic [31:0] STRAP_RST = 32'h0000_0F00,
    parameter logic [31:0] REV_OLD   = 32'h0100_0A11,
    parameter logic [31:0] REV_NEW   = 32'h0200_0B22
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [1:0]            bus_size,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  err_pulse,
    output logic [1:0]            err_code,
    input  logic [31:0]           ro_freq_eval,
    input  logic [SCR_NUM*32-1:0] ro_scratch,
    input  logic [31:0]           ro_rng,
    input  logic [31:0]           ro_cnt_lo,
    input  logic [31:0]           ro_cnt_hi
);

    localparam int          IDX_W   = ADDR_W - 2;
    localparam logic [31:0] REV_VAL = NEWGEN ? REV_NEW : REV_OLD;

    logic [IDX_W-1:0]     idx;
    wr_act_e              act;
    logic                 rd_hit;
    logic                 dec_err;
    err_code_e            dec_code;
    logic                 unlocked;
    logic [DW-1:0]        strap_q;
    logic [DW-1:0]        gen_q [GEN_BASE:NUM_REGS-1];
    logic [DW-1:0]        gen_rd;
    logic [DW-1:0]        rd_mux;
    logic [SCR_SEL_W-1:0] sc_sel;
    logic [DW-1:0]        rdata_q;
    logic                 err_q;
    err_code_e            code_q;

    sysctl_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .LOCK_END (LOCK_END),
        .NEWGEN   (NEWGEN)
    ) u_decode (
        .wr       (bus_wr),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .size     (bus_size),
        .unlocked (unlocked),
        .idx      (idx),
        .act      (act),
        .rd_hit   (rd_hit),
        .err      (dec_err),
        .code     (dec_code)
    );

    sysctl_keyfsm #(
        .KEY_VALUE (KEY_VALUE)
    ) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (act == W_KEY),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    sysctl_strap #(
        .STRAP_RST (STRAP_RST)
    ) u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (act),
        .wdata   (bus_wdata),
        .strap_q (strap_q)
    );

    for (genvar g = GEN_BASE; g < NUM_REGS; g++) begin : g_gen
        always_ff @(posedge clk) begin
            if (!rst_n)                                    gen_q[g] <= '0;
            else if ((act == W_GEN) && (idx == IDX_W'(g))) gen_q[g] <= bus_wdata;
        end
    end

    always_comb begin
        gen_rd = '0;
        for (int g = GEN_BASE; g < NUM_REGS; g++) begin
            if (idx == IDX_W'(g)) gen_rd = gen_q[g];
        end
    end

    always_comb begin
        sc_sel = SCR_SEL_W'(idx - IDX_W'(SCR_BASE));
        if (idx == IDX_W'(KEY_IDX))           rd_mux = {31'b0, unlocked};
        else if (idx == IDX_W'(STRAP_IDX))    rd_mux = strap_q;
        else if (idx == IDX_W'(REV_IDX))      rd_mux = REV_VAL;
        else if (idx == IDX_W'(FREQ_IDX))     rd_mux = ro_freq_eval;
        else if (idx < IDX_W'(RNG_IDX))       rd_mux = ro_scratch[sc_sel*DW +: DW];
        else if (idx == IDX_W'(RNG_IDX))      rd_mux = ro_rng;
        else if (idx == IDX_W'(CNT_LO_IDX))   rd_mux = ro_cnt_lo;
        else if (idx == IDX_W'(CNT_HI_IDX))   rd_mux = ro_cnt_hi;
        else                                  rd_mux = gen_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
            code_q  <= ERR_OOB;
        end else begin
            if (bus_rd && !bus_wr) rdata_q <= rd_hit ? rd_mux : '0;
            err_q  <= dec_err;
            code_q <= dec_code;
        end
    end

    assign bus_rdata = rdata_q;
    assign err_pulse = err_q;
    assign err_code  = code_q;

    // R9
    size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && ((bus_size != SIZE_WORD) || (bus_addr[1:0] != 2'b00)))
            |=> (err_pulse && (err_code == 2'd3)));

    // R8
    oob_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && (bus_size == SIZE_WORD) && (bus_addr[1:0] == 2'b00)
         && ({1'b0, bus_addr[ADDR_W-1:2]} >= (IDX_W+1)'(NUM_REGS)))
            |=> ((bus_rdata == '0) && err_pulse && (err_code == 2'd0)));

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr || bus_rd) |=> !err_pulse);

endmodule

// File: tb/sysctl_regbank_bench.sv
`timescale 1ns/1ps
module sysctl_regbank_bench;

    localparam logic [31:0] KEY  = 32'hA5C3_1E70;
    localparam logic [31:0] SRST = 32'h0000_0F00;
    localparam logic [31:0] RVO  = 32'h0100_0A11;
    localparam logic [31:0] RVN  = 32'h0200_0B22;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [1:0]   bus_size = 2'b10;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  ro_freq = '0;
    logic [255:0] ro_scr = '0;
    logic [31:0]  ro_rng = '0;
    logic [31:0]  ro_lo = '0;
    logic [31:0]  ro_hi = '0;
    logic [31:0]  rd1, rd0;
    logic         ep1, ep0;
    logic [1:0]   ec1, ec0;
    logic [31:0]  r1, r0;
    logic         e1, e0;
    logic [1:0]   c1, c0;
    int           n_chk = 0;
    int           n_bad = 0;

    always #4 clk = ~clk;

    sysctl_regbank #(.NEWGEN(1'b1), .KEY_VALUE(KEY), .STRAP_RST(SRST),
                     .REV_OLD(RVO), .REV_NEW(RVN)) u_sysctl_regbank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(rd1), .err_pulse(ep1), .err_code(ec1),
        .ro_freq_eval(ro_freq), .ro_scratch(ro_scr), .ro_rng(ro_rng),
        .ro_cnt_lo(ro_lo), .ro_cnt_hi(ro_hi));

    sysctl_regbank #(.NEWGEN(1'b0), .KEY_VALUE(KEY), .STRAP_RST(SRST),
                     .REV_OLD(RVO), .REV_NEW(RVN)) u_sysctl_regbank_g0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(rd0), .err_pulse(ep0), .err_code(ec0),
        .ro_freq_eval(ro_freq), .ro_scratch(ro_scr), .ro_rng(ro_rng),
        .ro_cnt_lo(ro_lo), .ro_cnt_hi(ro_hi));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic re, input logic [7:0] a,
                       input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_wr = we; bus_rd = re; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        r1 = rd1; r0 = rd0; e1 = ep1; e0 = ep0; c1 = ec1; c0 = ec0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        acc(1'b1, 1'b0, a, 2'b10, d);
    endtask

    task automatic rd(input logic [7:0] a);
        acc(1'b0, 1'b1, a, 2'b10, '0);
    endtask

    task automatic t_reset;
        chk("R1 err after reset", {31'b0, ep1}, 32'd0);
        rd(8'h00); chk("R1 key new", r1, 32'd0); chk("R1 key old", r0, 32'd0);
        rd(8'h04); chk("R1 strap new", r1, SRST); chk("R1 strap old", r0, SRST);
        rd(8'h08); chk("R1 rev new", r1, RVN); chk("R1 rev old", r0, RVO);
        rd(8'h50); chk("R1 gen20", r1, 32'd0); chk("R1 no err on read", {31'b0, e1}, 32'd0);
    endtask

    task automatic t_window_locked;
        wr(8'h50, 32'h0000_1234);
        chk("R3 locked err", {31'b0, e1}, 32'd1); chk("R3 locked code", {30'b0, c1}, 32'd2);
        rd(8'h50); chk("R3 locked no write", r1, 32'd0);
        wr(8'hB0, 32'h0000_BEEF); chk("R10 past window no err", {31'b0, e1}, 32'd0);
        rd(8'hB0); chk("R10 past window data", r1, 32'h0000_BEEF);
        wr(8'h0C, 32'hFFFF_FFFF); chk("R7 ro beats lock code", {30'b0, c1}, 32'd1);
        wr(8'h04, 32'h0000_00FF); chk("R3 strap locked code", {30'b0, c0}, 32'd2);
        rd(8'h04); chk("R3 strap unchanged new", r1, SRST); chk("R3 strap unchanged old", r0, SRST);
    endtask

    task automatic t_key;
        wr(8'h00, 32'hDEAD_BEEF); chk("R2 miss no err", {31'b0, e1}, 32'd0);
        rd(8'h00); chk("R2 miss reads 0", r1, 32'd0);
        wr(8'h00, KEY); chk("R2 match no err", {31'b0, e1}, 32'd0);
        rd(8'h00); chk("R2 match reads 1", r1, 32'd1); chk("R2 match old", r0, 32'd1);
        wr(8'h50, 32'h0000_1234); chk("R3 open no err", {31'b0, e1}, 32'd0);
        rd(8'h50); chk("R10 gen full word", r1, 32'h0000_1234);
        wr(8'h00, 32'h0000_0001); rd(8'h00); chk("R2 relock", r1, 32'd0);
        wr(8'h00, KEY); rd(8'h00); chk("R2 reopen", r1, 32'd1);
    endtask

    task automatic t_strap;
        wr(8'h04, 32'h0000_00F0);
        rd(8'h04); chk("R4 or new", r1, 32'h0000_0FF0); chk("R6 load old", r0, 32'h0000_00F0);
        wr(8'h08, 32'h0000_0300);
        chk("R5 clr no err", {31'b0, e1}, 32'd0);
        chk("R6 rev write err", {31'b0, e0}, 32'd1); chk("R6 rev write code", {30'b0, c0}, 32'd1);
        rd(8'h04); chk("R5 clr new", r1, 32'h0000_0CF0); chk("R6 old strap kept", r0, 32'h0000_00F0);
        rd(8'h08); chk("R5 rev kept new", r1, RVN); chk("R6 rev kept old", r0, RVO);
        wr(8'h04, 32'h0000_0001);
        rd(8'h04); chk("R4 or keeps bits", r1, 32'h0000_0CF1); chk("R6 replace old", r0, 32'h0000_0001);
    endtask

    task automatic t_ro;
        ro_freq = 32'h1111_1111; ro_rng = 32'h5555_AAAA;
        ro_lo = 32'h0000_1234; ro_hi = 32'h0000_0001;
        for (int k = 0; k < 8; k++) ro_scr[k*32 +: 32] = 32'hA000_0000 + 32'(k);
        rd(8'h0C); chk("R7 freq", r1, 32'h1111_1111);
        rd(8'h18); chk("R7 scratch2", r1, 32'hA000_0002);
        rd(8'h2C); chk("R7 scratch7", r0, 32'hA000_0007);
        rd(8'h30); chk("R7 rng", r1, 32'h5555_AAAA);
        rd(8'h34); chk("R7 cnt lo", r1, 32'h0000_1234);
        rd(8'h38); chk("R7 cnt hi", r1, 32'h0000_0001);
        wr(8'h18, 32'hFFFF_FFFF);
        chk("R7 ro write err", {31'b0, e1}, 32'd1); chk("R7 ro write code", {30'b0, c1}, 32'd1);
        rd(8'h18); chk("R7 ro unchanged", r1, 32'hA000_0002);
    endtask

    task automatic t_oob;
        wr(8'hC8, 32'h0000_0077);
        chk("R8 oob wr err", {31'b0, e1}, 32'd1); chk("R8 oob wr code", {30'b0, c1}, 32'd0);
        rd(8'h50); chk("R8 no alias", r1, 32'h0000_1234);
        rd(8'hC8); chk("R8 oob rd data", r1, 32'd0); chk("R8 oob rd err", {31'b0, e1}, 32'd1);
        rd(8'hFC); chk("R8 top rd code", {30'b0, c1}, 32'd0);
    endtask

    task automatic t_size;
        wr(8'h52, 32'h0000_9999); chk("R9 misaligned code", {30'b0, c1}, 32'd3);
        rd(8'h50); chk("R9 misaligned no write", r1, 32'h0000_1234);
        acc(1'b1, 1'b0, 8'h50, 2'b01, 32'h0000_5555); chk("R9 half code", {30'b0, c0}, 32'd3);
        rd(8'h50); chk("R9 half no write", r1, 32'h0000_1234);
        acc(1'b0, 1'b1, 8'h50, 2'b00, '0);
        chk("R9 byte read data", r1, 32'd0); chk("R9 byte read code", {30'b0, c1}, 32'd3);
        acc(1'b1, 1'b0, 8'hC9, 2'b10, '0); chk("R9 size beats oob", {30'b0, c1}, 32'd3);
    endtask

    task automatic t_timing;
        wr(8'hC8, '0);
        chk("R11 pulse present", {31'b0, e1}, 32'd1);
        @(negedge clk); chk("R11 pulse one cycle", {31'b0, ep1}, 32'd0);
        acc(1'b1, 1'b1, 8'h54, 2'b10, 32'h0000_00AB);
        chk("R11 wr+rd keeps rdata", r1, 32'd0);
        rd(8'h54); chk("R11 wr+rd writes", r1, 32'h0000_00AB);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_window_locked;
        t_key;
        t_strap;
        t_ro;
        t_oob;
        t_size;
        t_timing;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule